// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block produces the fetch address for a small microcontroller core whose program and data memories sit on separate buses. A 13-bit program counter selects one word of a program space of up to 8K words. An eight-entry hardware return stack keeps the return addresses for subroutine calls and interrupts. Each cycle the core's decode logic raises at most one strobe: step, jump, call, return or interrupt-accept. Jump and call targets are made of an 11-bit in-page offset from the instruction and a 2-bit page number from a page-select register. If two strobes are raised together, a fixed priority picks the one that acts.

The parameter `MEM_WORDS` sets how much program space exists, 4096 or 8192 words. Every computed address is reduced modulo that size, so the counter wraps inside the space that exists. With 4096 words, page numbers 2 and 3 act the same as pages 0 and 1. The stack is a circular buffer of return addresses with no overflow or underflow indication. Operations are decoded into an enumerated operation (HOLD, STEP, JUMP, CALL, RET, IRQ) by a unique case, and each one acts at the clock edge that samples its strobe. The two resting conditions of the block are reset, where the counter is forced to 0000h, and run, where one operation is applied per cycle. Releasing `rst_n` moves the block from reset to run. Pulling `rst_n` low moves it back to reset at any time.

Top module: `pc_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 0000h, the stack pointer is cleared and every stack entry holds 0. A return issued straight after reset therefore loads 0000h.
- R2: STEP (`step_en`) loads `fetch_addr + 1` modulo `MEM_WORDS` at the next rising edge.
- R3: JUMP (`jump_en`) loads `{page_sel, target}` modulo `MEM_WORDS`. `page_sel` forms bits 12:11 and `target` forms bits 10:0. With 4096 words, `page_sel[1]` has no effect.
- R4: CALL (`call_en`) loads the same address as R3 and pushes `fetch_addr + 1` modulo `MEM_WORDS` onto the stack.
- R5: RET (`ret_en`) pops the most recently pushed entry that has not yet been popped and loads it into `fetch_addr`.
- R6: IRQ (`irq_take`) loads 0004h and pushes the current `fetch_addr`.
- R7: With no strobe raised, `fetch_addr` keeps its value.
- R8: When several strobes are raised together, exactly one acts, in the priority order IRQ, CALL, JUMP, RET, STEP.
- R9: `fetch_addr` is always below `MEM_WORDS`.
- R10: The stack holds 8 entries in a circle. A ninth push overwrites the oldest entry. Later pops return the newest 8 entries in reverse order and then wrap around to stale data, with no flag raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_take | input | 1 | Interrupt accepted: go to vector 0004h, push current address |
| call_en | input | 1 | Subroutine call to page/offset target, push return address |
| jump_en | input | 1 | Jump to page/offset target |
| ret_en | input | 1 | Return of any kind: pop the stack into the counter |
| step_en | input | 1 | Advance to the next sequential address |
| target | input | 11 | In-page offset from the instruction |
| page_sel | input | 2 | Page number from the page-select register |
| fetch_addr | output | 13 | Current program fetch address |

## Verification
The bench runs one instance with 8K words and one with 4K words, and checks both against the same stimulus. The first corner case is a step at the last word, 1FFFh or 0FFFh. The counter must return to 0000h there, and a design that applies the wrong mask either leaves the space or skips into a hole. The second is a jump with `page_sel` 2 or 3 on the 4K instance, which must land in pages 0 or 1. A design that keeps bit 12 produces an address above the space. The third is a run of nine calls followed by ten returns. Correct circular behaviour returns the newest address again after the eighth pop. A stack that saturates, or that drops the wrong entry, returns different addresses at that point.

Two further cases are covered. Simultaneous strobes show whether the priority is wrong, for example an interrupt that loses to a call and so sends the core to the call target. A return right after reset must load 0000h, and a design that fails to clear the stack loads an unknown value instead.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int PC_W    = 13;
    localparam int OFS_W   = 11;
    localparam int PAGE_W  = PC_W - OFS_W;
    localparam logic [PC_W-1:0] RESET_VEC = 13'h0000;
    localparam logic [PC_W-1:0] IRQ_VEC   = 13'h0004;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_STEP,
        OP_JUMP,
        OP_CALL,
        OP_RET,
        OP_IRQ
    } pcu_op_e;

endpackage

// File: rtl/pcu_arbiter.sv
module pcu_arbiter
    import pcu_pkg::*;
(
    input  logic    irq_take,
    input  logic    call_en,
    input  logic    jump_en,
    input  logic    ret_en,
    input  logic    step_en,
    output pcu_op_e op
);

    always_comb begin
        if (irq_take)     op = OP_IRQ;
        else if (call_en) op = OP_CALL;
        else if (jump_en) op = OP_JUMP;
        else if (ret_en)  op = OP_RET;
        else if (step_en) op = OP_STEP;
        else              op = OP_HOLD;
    end

endmodule

// File: rtl/pcu_stack.sv
module pcu_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_dec;

    assign ptr_dec = ptr - PTR_W'(1);
    assign top     = mem[ptr_dec];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (push) begin
            mem[ptr] <= din;
            ptr      <= ptr + PTR_W'(1);
        end else if (pop) begin
            ptr <= ptr_dec;
        end
    end

    // R10
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> ptr == PTR_W'($past(ptr) + PTR_W'(1)));

    // R5
    pop_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> ptr == PTR_W'($past(ptr) - PTR_W'(1)));

    // R4
    push_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> mem[$past(ptr)] == $past(din));

endmodule

// File: rtl/pcu_addr.sv
module pcu_addr
    import pcu_pkg::*;
#(
    parameter int MEM_WORDS = 8192
) (
    input  pcu_op_e            op,
    input  logic [PC_W-1:0]    pc,
    input  logic [OFS_W-1:0]   target,
    input  logic [PAGE_W-1:0]  page_sel,
    input  logic [PC_W-1:0]    stack_top,
    output logic [PC_W-1:0]    nxt,
    output logic [PC_W-1:0]    push_val,
    output logic               push,
    output logic               pop
);

    localparam logic [PC_W-1:0] MASK = PC_W'(MEM_WORDS - 1);

    logic [PC_W-1:0] seq;
    logic [PC_W-1:0] far;

    assign seq = (pc + PC_W'(1)) & MASK;
    assign far = {page_sel, target} & MASK;

    always_comb begin
        nxt      = pc;
        push_val = seq;
        push     = 1'b0;
        pop      = 1'b0;
        unique case (op)
            OP_HOLD: nxt = pc;
            OP_STEP: nxt = seq;
            OP_JUMP: nxt = far;
            OP_CALL: begin
                nxt  = far;
                push = 1'b1;
            end
            OP_RET: begin
                nxt = stack_top & MASK;
                pop = 1'b1;
            end
            OP_IRQ: begin
                nxt      = IRQ_VEC & MASK;
                push_val = pc;
                push     = 1'b1;
            end
            default: nxt = pc;
        endcase
    end

endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import pcu_pkg::*;
#(
    parameter int MEM_WORDS   = 8192,
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_take,
    input  logic              call_en,
    input  logic              jump_en,
    input  logic              ret_en,
    input  logic              step_en,
    input  logic [10:0]       target,
    input  logic [1:0]        page_sel,
    output logic [12:0]       fetch_addr
);

    localparam int AW = $clog2(MEM_WORDS);
    localparam logic [PC_W-1:0] MASK = PC_W'(MEM_WORDS - 1);

    pcu_op_e         op;
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] nxt;
    logic [PC_W-1:0] push_val;
    logic [PC_W-1:0] stack_top;
    logic            push;
    logic            pop;

    pcu_arbiter u_arb (
        .irq_take (irq_take),
        .call_en  (call_en),
        .jump_en  (jump_en),
        .ret_en   (ret_en),
        .step_en  (step_en),
        .op       (op)
    );

    pcu_addr #(.MEM_WORDS(MEM_WORDS)) u_addr (
        .op        (op),
        .pc        (pc),
        .target    (target),
        .page_sel  (page_sel),
        .stack_top (stack_top),
        .nxt       (nxt),
        .push_val  (push_val),
        .push      (push),
        .pop       (pop)
    );

    pcu_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (push_val),
        .top   (stack_top)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= RESET_VEC;
        else        pc <= nxt;
    end

    assign fetch_addr = pc;

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP) |=> fetch_addr == (($past(fetch_addr) + 13'd1) & MASK));

    // R6
    irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> fetch_addr == 13'h0004);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_take || call_en || jump_en || ret_en || step_en) |=> $stable(fetch_addr));

    // R8
    call_over_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_en && !irq_take) |-> push && !pop);

    generate
        if (AW < PC_W) begin : g_small
            // R9
            range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fetch_addr[PC_W-1:AW] == '0);
        end
    endgenerate

endmodule

// File: tb/pc_unit_tb.sv
module pc_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_take, call_en, jump_en, ret_en, step_en;
    logic [10:0] target;
    logic [1:0]  page_sel;
    logic [12:0] fa8, fa4;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int m_pc  [2];
    int m_ptr [2];
    int m_stk [2][8];
    int words [2] = '{8192, 4096};

    always #4 clk = ~clk;

    pc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .call_en(call_en),
        .jump_en(jump_en), .ret_en(ret_en), .step_en(step_en),
        .target(target), .page_sel(page_sel), .fetch_addr(fa8)
    );

    pc_unit #(.MEM_WORDS(4096)) u_dut4 (
        .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .call_en(call_en),
        .jump_en(jump_en), .ret_en(ret_en), .step_en(step_en),
        .target(target), .page_sel(page_sel), .fetch_addr(fa4)
    );

    function automatic string pick_tag(input logic i, c, j, r, s);
        int n = int'(i) + int'(c) + int'(j) + int'(r) + int'(s);
        if (n > 1) return "R8";
        if (i) return "R6";
        if (c) return "R4";
        if (j) return "R3";
        if (r) return "R5";
        if (s) return "R2";
        return "R7";
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_pc[k]  = 0;
            m_ptr[k] = 0;
            for (int e = 0; e < 8; e++) m_stk[k][e] = 0;
        end
    endtask

    task automatic model_apply(input logic i, c, j, r, s,
                               input logic [10:0] t, input logic [1:0] pg);
        for (int k = 0; k < 2; k++) begin
            int w;
            int cur;
            int far;
            w   = words[k];
            cur = m_pc[k];
            far = (int'(pg) * 2048 + int'(t)) % w;
            if (i) begin
                m_stk[k][m_ptr[k]] = cur;
                m_ptr[k] = (m_ptr[k] + 1) % 8;
                m_pc[k]  = 4;
            end else if (c) begin
                m_stk[k][m_ptr[k]] = (cur + 1) % w;
                m_ptr[k] = (m_ptr[k] + 1) % 8;
                m_pc[k]  = far;
            end else if (j) begin
                m_pc[k] = far;
            end else if (r) begin
                m_ptr[k] = (m_ptr[k] + 7) % 8;
                m_pc[k]  = m_stk[k][m_ptr[k]];
            end else if (s) begin
                m_pc[k] = (cur + 1) % w;
            end
        end
    endtask

    task automatic check_all(input string tag);
        checks++;
        if (int'(fa8) != m_pc[0]) begin
            errors++;
            $display("FAIL %s 8K: fetch_addr=%h expected=%h", tag, fa8, m_pc[0]);
        end
        checks++;
        if (int'(fa4) != m_pc[1]) begin
            errors++;
            $display("FAIL %s 4K: fetch_addr=%h expected=%h", tag, fa4, m_pc[1]);
        end
        checks++;
        if (fa4 >= 13'd4096) begin
            errors++;
            $display("FAIL R9 4K: fetch_addr=%h expected below 1000", fa4);
        end
    endtask

    task automatic cyc(input logic i, c, j, r, s, input logic [10:0] t,
                       input logic [1:0] pg, input string tag);
        string tg;
        tg = (tag == "") ? pick_tag(i, c, j, r, s) : tag;
        irq_take = i; call_en = c; jump_en = j; ret_en = r; step_en = s;
        target = t; page_sel = pg;
        model_apply(i, c, j, r, s, t, pg);
        @(negedge clk);
        check_all(tg);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq_take = 0; call_en = 0; jump_en = 0; ret_en = 0; step_en = 0;
        target = '0; page_sel = '0;
        model_reset();
        @(negedge clk);
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: timeout actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7319));
        rst_n = 1'b0;
        @(negedge clk);
        do_reset();

        // R1: pop straight after reset gives 0000h
        cyc(0, 0, 1, 0, 0, 11'h155, 2'd1, "R3");
        cyc(0, 0, 0, 1, 0, 11'h000, 2'd0, "R1");

        // R2 / R9: step at the top of each space
        cyc(0, 0, 1, 0, 0, 11'h7FF, 2'd3, "R9");
        cyc(0, 0, 0, 0, 1, 11'h000, 2'd0, "R2");
        cyc(0, 0, 1, 0, 0, 11'h7FF, 2'd1, "R3");
        cyc(0, 0, 0, 0, 1, 11'h000, 2'd0, "R9");

        // R3: high pages alias on 4K
        cyc(0, 0, 1, 0, 0, 11'h2A5, 2'd2, "R3");
        cyc(0, 0, 0, 0, 0, 11'h3FF, 2'd3, "R7");

        // R6 then R5: interrupt and return
        cyc(0, 0, 0, 0, 1, 11'h000, 2'd0, "R2");
        cyc(1, 0, 0, 0, 0, 11'h111, 2'd1, "R6");
        cyc(0, 0, 0, 1, 0, 11'h000, 2'd0, "R5");

        // R8: simultaneous strobes
        cyc(1, 1, 1, 1, 1, 11'h0F0, 2'd2, "R8");
        cyc(0, 1, 1, 1, 1, 11'h0F0, 2'd2, "R8");
        cyc(0, 0, 1, 1, 1, 11'h00F, 2'd1, "R8");
        cyc(0, 0, 0, 1, 1, 11'h000, 2'd0, "R8");

        // R10: nine calls then ten returns
        do_reset();
        for (int n = 0; n < 9; n++) begin
            cyc(0, 1, 0, 0, 0, 11'(n * 100 + 7), 2'(n), "R4");
            cyc(0, 0, 0, 0, 1, 11'h000, 2'd0, "R2");
        end
        for (int n = 0; n < 10; n++) begin
            cyc(0, 0, 0, 1, 0, 11'h000, 2'd0, "R10");
        end

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int sel;
            logic i, c, j, r, s;
            sel = int'($urandom % 32);
            i = 0; c = 0; j = 0; r = 0; s = 0;
            if (sel == 0)       i = 1;
            else if (sel < 4)   c = 1;
            else if (sel < 8)   j = 1;
            else if (sel < 12)  r = 1;
            else if (sel < 26)  s = 1;
            else if (sel == 26) begin
                i = 1'($urandom); c = 1'($urandom); j = 1'($urandom);
                r = 1'($urandom); s = 1'($urandom);
            end
            if (n % 997 == 500) do_reset();
            else cyc(i, c, j, r, s, 11'($urandom), 2'($urandom), "");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule